// File: doc/BRIEF.md
# Microcoded Flash Bus Waveform Sequencer

This block generates the control waveforms for a byte-wide parallel flash from microcode held in a small pattern RAM. It does not hard-wire the waveforms in logic. Each RAM word describes one bus cycle of the flash interface:

- four quarter-cycle chip-select phases;
- half-cycle phases for write enable, read enable, command latch and address latch;
- a flag that drives a stored byte onto the IO bus;
- a flag that captures the IO input;
- a terminate flag.

A pattern starts at an offset and steps through one word per clock until it reaches a word whose terminate flag is set.

Software loads the microcode through a small register port. A mode register holds an operation code and a 6-bit RAM pointer. Bus accesses on the access channel then do one of the following, depending on the operation code:

- write the data register into the RAM;
- read a RAM word back into the data register;
- start the fixed read or write patterns;
- start a pattern at a chosen offset.

Sending a flash command or address byte works like this:

1. Load the byte into the top of the address register.
2. Select run mode with the offset of the matching pattern.
3. Issue one write access.

The access channel is valid/ready. `acc_ready` is low for the whole time a pattern runs. An access presented then is held off, not dropped, and is taken on the first cycle after the run ends. The capture output is a plain one-cycle pulse with no back-pressure, because flash read timing cannot be stalled.

Top module: `flash_wave_seq`

## Requirements
- R1: With mode opcode 1 (bits 31:28 of the mode register), an accepted access writes the data register into the RAM word addressed by mode bits 5:0. Those bits then increment modulo 64.
- R2: With opcode 2, an accepted access loads the addressed RAM word into the data register. The mode pointer then increments modulo 64.
- R3: With opcode 0, an accepted read access starts the pattern at word 0 and an accepted write access starts the pattern at word 24.
- R4: With opcode 3, an accepted write access starts the pattern at the offset in mode bits 5:0. A read access is accepted and starts nothing.
- R5: A running pattern shows one word per clock, beginning the cycle after acceptance. The run ends after a word whose bit 0 (the LSB, terminate) is set, or after word 63.
- R6: Chip select follows word bits 31:28, with `cs_n[3]` as the first quarter. Write enable in each half follows the second bit of a two-bit pair: `we_n[1]`=bit 22 for the first half and `we_n[0]`=bit 20 for the second half. A pair value of 10 therefore drives low and 11 drives high.
- R7: Command latch follows bits 19:18, read enable (active low) follows bits 17:16, and address latch follows bits 15:14. In each two-bit output, index 1 is the first half-cycle.
- R8: When bits 5:4 of the running word are both 1, `io_oe` is high and `io_out` carries bits 31:24 of the address register.
- R9: When bit 2 of the running word is set, `io_in` is sampled at the end of that cycle. `cap_valid` is high for the following cycle, with the sampled byte on `cap_data`.
- R10: When no pattern runs, including after reset, the outputs rest at their idle levels: `cs_n`=1111, `we_n`=11, `re_n`=11, `cle`=00, `ale`=00, `io_oe`=0, `io_out`=0. `busy` is 0.
- R11: `busy` is high from the cycle after acceptance until the last word ends. `acc_ready` is low whenever `busy` is high.
- R12: `reg_sel` selects the register for `reg_wr` and for the combinational `reg_rdata`:
  - 0 is the mode register, read back as `{op, zeros, pointer}`;
  - 1 is the 32-bit data register;
  - 2 is the address register, which holds only bits 31:24 and reads back zeros below them;
  - 3 reads as zero.

  A register write takes priority over an access update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| acc_valid | input | 1 | Bus access request |
| acc_write | input | 1 | Access direction, 1 = write |
| acc_ready | output | 1 | Access accepted when high with valid |
| busy | output | 1 | Pattern running |
| cs_n | output | 4 | Chip select per quarter-cycle |
| we_n | output | 2 | Write enable per half-cycle |
| re_n | output | 2 | Read enable per half-cycle |
| cle | output | 2 | Command latch per half-cycle |
| ale | output | 2 | Address latch per half-cycle |
| io_oe | output | 1 | IO output enable |
| io_out | output | 8 | IO output byte |
| io_in | input | 8 | IO input byte |
| cap_valid | output | 1 | Captured byte valid pulse |
| cap_data | output | 8 | Captured byte |

## Verification
The bench loads 64 random microwords and reads them all back. The load and the read-back each wrap the pointer past word 63, so a pointer that failed to wrap, or that advanced on the wrong opcode, would corrupt the read-back and the final pointer value.

Runs start from 0, 24, random offsets and a directed segment with no terminate bit. A sequencer that ignored the word-63 stop would run off the end. One that stopped late or early would show the wrong word, or show idle pins while `busy` disagreed.

Every cycle of every run compares all pins against a decode of the bench's own copy of the RAM. Swapped half-cycle or quarter-cycle bit orders, or a capture that lands one cycle off, are caught there. A run-mode read is also tried, which must leave the pins idle.

// File: rtl/flash_wave_pkg.sv
package flash_wave_pkg;
  typedef enum logic [3:0] {
    OP_NORMAL = 4'h0,
    OP_WRAM   = 4'h1,
    OP_RRAM   = 4'h2,
    OP_RUN    = 4'h3
  } seq_op_e;

  typedef struct packed {
    logic [3:0] cs_n;
    logic [1:0] we_n;
    logic [1:0] re_n;
    logic [1:0] cle;
    logic [1:0] ale;
    logic       io_oe;
    logic [7:0] io_out;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 4'hF, we_n: 2'b11, re_n: 2'b11,
                                  cle: 2'b00, ale: 2'b00, io_oe: 1'b0,
                                  io_out: 8'h00};

  // microword field positions (LSB-numbered)
  localparam int F_CS_HI  = 31;
  localparam int F_WE_A   = 22;
  localparam int F_WE_B   = 20;
  localparam int F_CLE_HI = 19;
  localparam int F_RE_HI  = 17;
  localparam int F_ALE_HI = 15;
  localparam int F_DRV_HI = 5;
  localparam int F_CAP    = 2;
  localparam int F_END    = 0;
endpackage

// File: rtl/flash_wave_ram.sv
module flash_wave_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  assert_store_R1: assert property (@(posedge clk)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/flash_wave_pc.sv
module flash_wave_pc #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ofs,
  input  logic          end_bit,
  output logic          busy,
  output logic [AW-1:0] pc
);
  logic last_word;
  assign last_word = end_bit || (pc == {AW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pc   <= '0;
    end else if (busy) begin
      if (last_word) busy <= 1'b0;
      else           pc   <= pc + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      pc   <= start_ofs;
    end
  end

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_word |=> busy && pc == $past(pc) + 1'b1);
  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && last_word |=> !busy);
endmodule

// File: rtl/flash_wave_decode.sv
module flash_wave_decode
  import flash_wave_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic [31:0] word,
  input  logic [7:0]  drive_byte,
  input  logic [7:0]  io_in,
  output pins_t       pins,
  output logic        cap_valid,
  output logic [7:0]  cap_data
);
  pins_t run_pins;
  logic  unused_word;

  assign unused_word = ^{word[27:23], word[21], word[13:6], word[3], word[1]};

  always_comb begin
    run_pins.cs_n   = word[F_CS_HI -: 4];
    run_pins.we_n   = {word[F_WE_A], word[F_WE_B]};
    run_pins.cle    = word[F_CLE_HI -: 2];
    run_pins.re_n   = word[F_RE_HI -: 2];
    run_pins.ale    = word[F_ALE_HI -: 2];
    run_pins.io_oe  = &word[F_DRV_HI -: 2];
    run_pins.io_out = run_pins.io_oe ? drive_byte : 8'h00;
  end

  assign pins = busy ? run_pins : PINS_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else begin
      cap_valid <= busy && word[F_CAP];
      if (busy && word[F_CAP]) cap_data <= io_in;
    end
  end

  assert_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && word[F_CAP] |=> cap_valid && cap_data == $past(io_in));
endmodule

// File: rtl/flash_wave_seq.sv
module flash_wave_seq
  import flash_wave_pkg::*;
#(
  parameter int AW        = 6,
  parameter int READ_OFS  = 0,
  parameter int WRITE_OFS = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        acc_valid,
  input  logic        acc_write,
  output logic        acc_ready,
  output logic        busy,
  output logic [3:0]  cs_n,
  output logic [1:0]  we_n,
  output logic [1:0]  re_n,
  output logic [1:0]  cle,
  output logic [1:0]  ale,
  output logic        io_oe,
  output logic [7:0]  io_out,
  input  logic [7:0]  io_in,
  output logic        cap_valid,
  output logic [7:0]  cap_data
);
  localparam int PADW = 28 - AW;

  logic [3:0]    mode_op;
  logic [AW-1:0] mode_ptr;
  logic [31:0]   data_q;
  logic [7:0]    addr_byte;
  logic          acc_fire, start, ram_we;
  logic [AW-1:0] start_ofs, pc;
  logic [31:0]   run_word, ptr_word;
  pins_t         pins;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata[27:AW];
  assign acc_ready = !busy;
  assign acc_fire  = acc_valid && acc_ready;
  assign ram_we    = acc_fire && (mode_op == OP_WRAM);
  assign start     = acc_fire && ((mode_op == OP_NORMAL) ||
                                  (mode_op == OP_RUN && acc_write));

  always_comb begin
    if (mode_op == OP_RUN) start_ofs = mode_ptr;
    else if (acc_write)    start_ofs = AW'(WRITE_OFS);
    else                   start_ofs = AW'(READ_OFS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_op   <= OP_NORMAL;
      mode_ptr  <= '0;
      data_q    <= '0;
      addr_byte <= '0;
    end else begin
      if (reg_wr && reg_sel == 2'd0) begin
        mode_op  <= reg_wdata[31:28];
        mode_ptr <= reg_wdata[AW-1:0];
      end else if (acc_fire && (mode_op == OP_WRAM || mode_op == OP_RRAM)) begin
        mode_ptr <= mode_ptr + 1'b1;
      end
      if (reg_wr && reg_sel == 2'd1)             data_q <= reg_wdata;
      else if (acc_fire && mode_op == OP_RRAM)   data_q <= ptr_word;
      if (reg_wr && reg_sel == 2'd2)             addr_byte <= reg_wdata[31:24];
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {mode_op, {PADW{1'b0}}, mode_ptr};
      2'd1:    reg_rdata = data_q;
      2'd2:    reg_rdata = {addr_byte, 24'h0};
      default: reg_rdata = '0;
    endcase
  end

  flash_wave_ram #(.AW(AW), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(mode_ptr), .wdata(data_q),
    .raddr_a(pc), .rdata_a(run_word), .raddr_b(mode_ptr), .rdata_b(ptr_word));

  flash_wave_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ofs(start_ofs),
    .end_bit(run_word[F_END]), .busy(busy), .pc(pc));

  flash_wave_decode u_dec (
    .clk(clk), .rst_n(rst_n), .busy(busy), .word(run_word),
    .drive_byte(addr_byte), .io_in(io_in), .pins(pins),
    .cap_valid(cap_valid), .cap_data(cap_data));

  assign cs_n   = pins.cs_n;
  assign we_n   = pins.we_n;
  assign re_n   = pins.re_n;
  assign cle    = pins.cle;
  assign ale    = pins.ale;
  assign io_oe  = pins.io_oe;
  assign io_out = pins.io_out;

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n == 4'hF && we_n == 2'b11 && !io_oe && cle == 2'b00);
  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && mode_op == OP_WRAM && !(reg_wr && reg_sel == 2'd0)
    |=> mode_ptr == $past(mode_ptr) + 1'b1);
  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && pc == $past(start_ofs));
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && acc_valid |=> $stable(mode_ptr) || $past(reg_wr));
endmodule

// File: tb/flash_wave_seq_test.sv
module flash_wave_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_ready, busy;
  logic [3:0]  cs_n;
  logic [1:0]  we_n, re_n, cle, ale;
  logic        io_oe, cap_valid;
  logic [7:0]  io_out, io_in = '0, cap_data;

  int checks = 0, fails = 0;
  logic [31:0] model [64];
  logic [7:0]  abyte;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wave_seq uut (.*);

  function automatic logic [20:0] exp_pins(input logic [31:0] w, input logic [7:0] ab);
    logic oe;
    oe = w[5] & w[4];
    return {w[31:28], w[22], w[20], w[17:16], w[19:18], w[15:14], oe, oe ? ab : 8'h00};
  endfunction

  localparam logic [20:0] IDLE = {4'hF, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 8'h00};

  function automatic logic [20:0] act_pins();
    return {cs_n, we_n, re_n, cle, ale, io_oe, io_out};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic access(input bit wr);
    @(negedge clk); acc_valid = 1'b1; acc_write = wr;
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic run_pat(input int start, input bit wr);
    int pc; bit prev_cap; logic [7:0] prev_v, v; bit fin;
    access(wr);
    pc = start; prev_cap = 0; prev_v = 0;
    forever begin
      check(act_pins() == exp_pins(model[pc], abyte), "R6/R7/R8 pins", 32'(act_pins()), 32'(exp_pins(model[pc], abyte)));
      check(busy && !acc_ready, "R11 busy", {busy, acc_ready}, 2'b10);
      check(cap_valid == prev_cap && (!prev_cap || cap_data == prev_v), "R9 capture",
            {cap_valid, cap_data}, {prev_cap, prev_v});
      v = 8'($urandom); io_in = v;
      prev_cap = model[pc][2]; prev_v = v;
      fin = model[pc][0] || pc == 63;
      @(negedge clk);
      if (fin) break;
      pc++;
    end
    check(!busy && act_pins() == IDLE, "R5/R10 end", {busy, 11'h0, act_pins()}, {1'b0, 11'h0, IDLE});
    check(cap_valid == prev_cap && (!prev_cap || cap_data == prev_v), "R9 last capture",
          {cap_valid, cap_data}, {prev_cap, prev_v});
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) begin
      model[i] = $urandom;
      model[i][0] = ($urandom % 5) == 0;
      if (i >= 50) model[i][0] = 1'b0;
    end
    model[7][0] = 1'b1;  model[7][2] = 1'b1;
    model[30][5:4] = 2'b11;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(act_pins() == IDLE && !busy && acc_ready && !cap_valid, "R10 reset",
          32'(act_pins()), 32'(IDLE));
    reg_sel = 2'd0; #1;
    check(reg_rdata == 32'h0, "R12 mode reset", reg_rdata, 32'h0);

    // R12 register map
    abyte = 8'($urandom);
    wreg(2'd2, {abyte, 24'hABCDEF});
    reg_sel = 2'd2; #1;
    check(reg_rdata == {abyte, 24'h0}, "R12 addr reg", reg_rdata, {abyte, 24'h0});
    reg_sel = 2'd3; #1;
    check(reg_rdata == 32'h0, "R12 sel3", reg_rdata, 32'h0);

    // R1 program RAM
    wreg(2'd0, 32'h1000_0000);
    for (int i = 0; i < 64; i++) begin
      wreg(2'd1, model[i]);
      access(1'b1);
    end
    reg_sel = 2'd0; #1;
    check(reg_rdata == 32'h1000_0000, "R1 pointer wrap", reg_rdata, 32'h1000_0000);
    check(!busy && act_pins() == IDLE, "R1 no run", 32'(act_pins()), 32'(IDLE));

    // R2 read back, starting at 10 and wrapping
    wreg(2'd0, 32'h2000_000A);
    for (int k = 0; k < 64; k++) begin
      int a; a = (10 + k) % 64;
      access(1'b0);
      reg_sel = 2'd1; #1;
      check(reg_rdata == model[a], "R2 readback", reg_rdata, model[a]);
    end
    reg_sel = 2'd0; #1;
    check(reg_rdata == 32'h2000_000A, "R2 pointer wrap", reg_rdata, 32'h2000_000A);

    // R3 normal mode
    wreg(2'd0, 32'h0000_0000);
    run_pat(0, 1'b0);
    run_pat(24, 1'b1);

    // R4 run mode read does nothing
    wreg(2'd0, 32'h3000_0005);
    access(1'b0);
    check(!busy && act_pins() == IDLE, "R4 run-mode read ignored", 32'(act_pins()), 32'(IDLE));
    @(negedge clk);
    check(!busy && !cap_valid, "R4 still idle", {busy, cap_valid}, 2'b00);

    // R4/R5 directed offsets, including stop at word 63
    run_pat(5, 1'b1);
    wreg(2'd0, 32'h3000_0032);
    run_pat(50, 1'b1);
    wreg(2'd0, 32'h3000_003F);
    run_pat(63, 1'b1);
    wreg(2'd0, 32'h3000_001E);
    run_pat(30, 1'b1);

    // random offsets and address bytes
    for (int n = 0; n < 40; n++) begin
      int ofs; ofs = $urandom % 64;
      abyte = 8'($urandom);
      wreg(2'd2, {abyte, 24'h0});
      wreg(2'd0, 32'h3000_0000 | 32'(ofs));
      run_pat(ofs, 1'b1);
    end

    // R11 held access is taken after the run ends
    wreg(2'd0, 32'h0000_0000);
    @(negedge clk); acc_valid = 1'b1; acc_write = 1'b0;
    @(negedge clk);
    check(busy && !acc_ready, "R11 held", {busy, acc_ready}, 2'b10);
    while (busy) @(negedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    check(busy, "R11 second access accepted", {31'h0, busy}, 32'h1);
    while (busy) @(negedge clk);

    done = 1;
    report();
  end
endmodule